// File: doc/BRIEF.md
# SPI Serial Clock and Mode Generator

This block produces the serial clock, the chip-select levels and the sample/launch timing for a serial-peripheral master that drives up to four devices. A transfer engine, which lies outside this block, picks a device with `cs_idx` and holds `run` high for as long as it wants clock edges. The block answers with SCLK transitions and a one-cycle strobe at each transition. The strobe tells the engine whether to sample input data or to launch the next output bit. The engine drops `run` once it has seen the last edge it needs, and the block ends the transfer cleanly.

Two configuration words are written through a one-cycle write port. The clock word (`cfg_sel` = 0) holds an enable bit and a divider. The device word (`cfg_sel` = 1) holds a small mode byte for each chip select: resting clock level, chip-select active level, clock phase and a lead-in delay. The block clock `clk` runs at twice the functional clock, so one functional-clock period is two `clk` cycles. SCLK therefore runs at the functional clock divided by (divider + 1).

A divider written while a transfer is in progress is held back and takes effect only once the block is idle or disabled. This allows software to reprogram the rate safely.

Top module: `sckgen_top`

## Requirements
- R1: After reset, `sclk` is 0, every `cs_line` bit is 1, and both strobes are 0.
- R2: While idle, `sclk` rests at bit 0 (resting level) of the mode byte for the chip select named by `cs_idx`. Each `cs_line[n]` rests at the inverse of bit 1 (active-high select) of its own byte. Chip select n's byte sits at device-word bits [8n+7:8n].
- R3: With the enable set, a `run` seen while idle drives the selected `cs_line` to its active level in the next cycle. All other chip-select lines stay at their resting level.
- R4: The first SCLK transition comes (divider + 1) + 2·delay `clk` cycles after the chip select goes active. The delay is bits 4:3 of the byte, 0 to 3 functional-clock periods.
- R5: Later SCLK transitions are spaced divider + 1 `clk` cycles apart. The divider is clock-word bits 15:0, so each SCLK period lasts divider + 1 functional-clock periods.
- R6: Each SCLK transition is accompanied, in the same cycle, by exactly one strobe, and no strobe appears at any other time. With phase bit 2 clear, the edge that leaves the resting level carries `sample_stb` and the returning edge carries `launch_stb`. With phase bit 2 set, the two are swapped.
- R7: After `run` falls, the transfer ends at the next pacing point at which `sclk` is at its resting level. The chip select is then released divider + 1 cycles after the last transition, so an even number of transitions is produced.
- R8: While the enable (clock-word bit 31) is clear, `run` has no effect: no chip select goes active, `sclk` does not move, and no strobe is issued.
- R9: A divider written with the enable kept set during a transfer does not change the edge spacing of that transfer. The next transfer uses it.
- R10: Clearing the enable during a transfer returns `sclk` to the resting level and releases the chip select two cycles after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the functional clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | One-cycle configuration write strobe |
| cfg_sel | input | 1 | 0 selects the clock word, 1 selects the device word |
| cfg_wdata | input | 32 | Configuration write data |
| run | input | 1 | Transfer request level from the engine |
| cs_idx | input | 2 | Chip select to use for the next transfer |
| sclk | output | 1 | Serial clock |
| cs_line | output | 4 | Chip-select outputs at their physical levels |
| sample_stb | output | 1 | Pulse: capture input data at this SCLK edge |
| launch_stb | output | 1 | Pulse: drive the next output bit at this SCLK edge |

## Verification
Wrong state inside the pacing counter shows up at the ports straight away as a misplaced SCLK transition. The bench measures every gap, including the lead-in before the first edge. If the resting-level or phase copy taken at the start of a transfer is wrong, the strobe kind swaps at the very first edge, or the transfer ends with SCLK stranded at the wrong level. A divider copy that changes too early shows up one gap after the mid-transfer write. A state machine stuck busy leaves a chip select active, and the release check sees that within divider + 1 cycles of the final edge.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;
  localparam int CFG_W  = 32;
  localparam int EN_BIT = 31;
  localparam int BYTE_W = 8;
  localparam int LANE_W = 5;
  localparam int DLY_W  = 2;

  // per-chip-select mode, low bits of that select's byte
  typedef struct packed {
    logic [DLY_W-1:0] dly;
    logic             cpha;
    logic             cs_hi;
    logic             cpol;
  } lane_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_t;
endpackage

// File: rtl/sckgen_regs.sv
module sckgen_regs
  import sckgen_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic                     cfg_sel,
  input  logic [CFG_W-1:0]         cfg_wdata,
  input  logic                     quiet,
  output logic                     sclk_on,
  output logic [DIV_W-1:0]         div_now,
  output logic [LANE_W*NUM_CS-1:0] lanes
);
  logic [DIV_W-1:0] div_pend;
  logic             clk_wr;
  logic             dev_wr;

  assign clk_wr = cfg_we && !cfg_sel;
  assign dev_wr = cfg_we && cfg_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_on  <= 1'b0;
      div_pend <= '0;
      div_now  <= '0;
      lanes    <= '0;
    end else begin
      if (clk_wr) begin
        sclk_on  <= cfg_wdata[EN_BIT];
        div_pend <= cfg_wdata[DIV_W-1:0];
      end
      if (dev_wr) begin
        for (int i = 0; i < NUM_CS; i++) begin
          lanes[i*LANE_W +: LANE_W] <= cfg_wdata[i*BYTE_W +: LANE_W];
        end
      end
      // the divider in use only moves while no transfer can see it
      if (quiet || !sclk_on) begin
        div_now <= clk_wr ? cfg_wdata[DIV_W-1:0] : div_pend;
      end
    end
  end
endmodule

// File: rtl/sckgen_pacer.sv
module sckgen_pacer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             active,
  input  logic [CNT_W-1:0] reload,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = active && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (active) begin
      cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sckgen_csdrv.sv
module sckgen_csdrv (
  input  logic clk,
  input  logic rst,
  input  logic act_hi,
  input  logic sel_nxt,
  output logic cs_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_o <= 1'b1;
    end else begin
      cs_o <= sel_nxt ? act_hi : ~act_hi;
    end
  end
endmodule

// File: rtl/sckgen_top.sv
module sckgen_top
  import sckgen_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 16,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              run,
  input  logic [SEL_W-1:0]  cs_idx,
  output logic              sclk,
  output logic [NUM_CS-1:0] cs_line,
  output logic              sample_stb,
  output logic              launch_stb
);
  localparam int CNT_W = DIV_W + 1;

  logic                     sclk_on;
  logic [DIV_W-1:0]         div_now;
  logic [LANE_W*NUM_CS-1:0] lanes;
  lane_t                    lane_arr [NUM_CS];
  lane_t                    sel_lane;

  st_t              st_q, st_d;
  logic [SEL_W-1:0] cs_q, cs_d;
  logic             pol_q, pha_q;
  logic             busy_w, start, toggle, expire, lead;
  logic [CNT_W-1:0] load_val;
  logic [NUM_CS-1:0] sel_nxt;

  sckgen_regs #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .quiet(!busy_w), .sclk_on(sclk_on),
    .div_now(div_now), .lanes(lanes)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_lane
    assign lane_arr[g] = lane_t'(lanes[g*LANE_W +: LANE_W]);
  end

  assign sel_lane = lane_arr[cs_idx];
  assign busy_w   = (st_q == ST_RUN);
  assign start    = (st_q == ST_IDLE) && run && sclk_on;
  // lead-in merged into the first countdown: half period plus 2*delay
  assign load_val = CNT_W'(div_now) + CNT_W'({sel_lane.dly, 1'b0});
  assign lead     = (sclk == pol_q);

  sckgen_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk(clk), .rst(rst), .load(start), .load_val(load_val),
    .active(busy_w), .reload(CNT_W'(div_now)), .expire(expire)
  );

  always_comb begin
    st_d   = st_q;
    cs_d   = cs_q;
    toggle = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d = ST_RUN;
          cs_d = cs_idx;
        end
      end
      ST_RUN: begin
        if (!sclk_on) begin
          st_d = ST_IDLE;
        end else if (expire) begin
          if (!run && lead) st_d = ST_IDLE;
          else              toggle = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cs_q       <= '0;
      pol_q      <= 1'b0;
      pha_q      <= 1'b0;
      sclk       <= 1'b0;
      sample_stb <= 1'b0;
      launch_stb <= 1'b0;
    end else begin
      st_q       <= st_d;
      cs_q       <= cs_d;
      sample_stb <= toggle && (lead ^ pha_q);
      launch_stb <= toggle && !(lead ^ pha_q);
      if (start) begin
        pol_q <= sel_lane.cpol;
        pha_q <= sel_lane.cpha;
        sclk  <= sel_lane.cpol;
      end else if (st_d == ST_IDLE) begin
        sclk  <= busy_w ? pol_q : sel_lane.cpol;
      end else if (toggle) begin
        sclk  <= ~sclk;
      end
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign sel_nxt[g] = (st_d == ST_RUN) && (cs_d == SEL_W'(g));
    sckgen_csdrv u_drv (
      .clk(clk), .rst(rst), .act_hi(lane_arr[g].cs_hi),
      .sel_nxt(sel_nxt[g]), .cs_o(cs_line[g])
    );
  end
endmodule

// File: rtl/sckgen_chk.sv
module sckgen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sclk,
  input logic             sample_stb,
  input logic             launch_stb,
  input logic             busy,
  input logic             sclk_on,
  input logic [DIV_W-1:0] div_now
);
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && launch_stb));

  assert_strobe_on_edge_R6: assert property (@(posedge clk) disable iff (rst)
    (sample_stb || launch_stb) |-> (sclk != $past(sclk)));

  assert_no_idle_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(sample_stb || launch_stb));

  assert_disable_stops_R10: assert property (@(posedge clk) disable iff (rst)
    !sclk_on |=> !busy);

  assert_div_held_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(div_now));
endmodule

bind sckgen_top sckgen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .sample_stb(sample_stb),
  .launch_stb(launch_stb), .busy(busy_w), .sclk_on(sclk_on),
  .div_now(div_now)
);

// File: tb/tb_sckgen_top.sv
module tb_sckgen_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        run = 1'b0;
  logic [1:0]  cs_idx = '0;
  logic        sclk;
  logic [3:0]  cs_line;
  logic        sample_stb;
  logic        launch_stb;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_P/2) clk = ~clk;

  sckgen_top dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .run(run), .cs_idx(cs_idx), .sclk(sclk),
    .cs_line(cs_line), .sample_stb(sample_stb), .launch_stb(launch_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected strobe kind: 1 means sample, from R6
  function automatic bit want_sample(input bit leaving_rest, input bit pha);
    return pha ? !leaving_rest : leaving_rest;
  endfunction

  function automatic logic [31:0] clk_word(input bit en, input int dv);
    return {en, 15'd0, 16'(dv)};
  endfunction

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xfer(input int cs, input int dv, input int dl, input bit pol,
                      input bit pha, input bit hi, input int nb,
                      input bit do_cfg, input int mid_div);
    logic [31:0] dev;
    bit          his[4];
    int          t, last, edges, spur, gexp;
    bit          done, lead;
    logic        prev;
    dev = '0;
    for (int j = 0; j < 4; j++) begin
      logic [4:0] b;
      b = (j == cs) ? {2'(dl), pha, hi, pol} : 5'($urandom);
      his[j] = b[1];
      dev[j*8 +: 5] = b;
    end
    wr(1'b1, dev);
    if (do_cfg) wr(1'b0, clk_word(1'b1, dv));
    @(negedge clk);
    cs_idx = 2'(cs); run = 1'b1;
    @(negedge clk);
    chk("R3 active", int'(cs_line[cs]), int'(hi));
    for (int j = 0; j < 4; j++)
      if (j != cs) chk("R3 others idle", int'(cs_line[j]), int'(!his[j]));
    t = 0; last = 0; edges = 0; spur = 0; done = 1'b0; prev = sclk;
    for (int k = 0; k < 3000 && !done; k++) begin
      @(negedge clk);
      t++;
      if (cfg_we) cfg_we = 1'b0;
      if (sclk !== prev) begin
        edges++;
        gexp = (edges == 1) ? dv + 1 + 2*dl : dv + 1;
        chk((edges == 1) ? "R4" : ((mid_div >= 0 && edges > 2) ? "R9" : "R5"),
            t - last, gexp);
        lead = (sclk != pol);
        chk("R6 sample", int'(sample_stb), int'(want_sample(lead, pha)));
        chk("R6 launch", int'(launch_stb), int'(!want_sample(lead, pha)));
        last = t; prev = sclk;
        if (edges == 2*nb) run = 1'b0;
        if (mid_div >= 0 && edges == 2) begin
          cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = clk_word(1'b1, mid_div);
        end
      end else if (sample_stb || launch_stb) begin
        spur++;
      end
      if (cs_line[cs] !== hi) begin
        done = 1'b1;
        chk("R7 release delay", t - last, dv + 1);
        chk("R7 edge count", edges, 2*nb);
        chk("R7 rest level", int'(sclk), int'(pol));
      end
    end
    chk("R7 finished", int'(done), 1);
    chk("R6 no stray strobe", spur, 0);
    run = 1'b0;
  endtask

  initial begin
    int moved;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 cs", int'(cs_line), 4'hF);
    chk("R1 strobes", int'(sample_stb | launch_stb), 0);

    // R2: idle levels follow the selected lane
    wr(1'b1, 32'h0102_0003);
    cs_idx = 2'd0;
    repeat (2) @(negedge clk);
    chk("R2 rest cs0", int'(sclk), 1);
    chk("R2 cs idle", int'(cs_line), 4'b1010);
    cs_idx = 2'd1;
    repeat (2) @(negedge clk);
    chk("R2 rest cs1", int'(sclk), 0);

    // R8: run is ignored with the enable clear
    moved = 0;
    run = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (sclk !== 1'b0 || cs_line !== 4'b1010 || sample_stb || launch_stb) moved++;
    end
    run = 1'b0;
    chk("R8 disabled", moved, 0);

    // directed corners: fastest clock, longest lead-in, phase 1
    xfer(0, 0, 0, 1'b0, 1'b0, 1'b0, 2, 1'b1, -1);
    xfer(3, 2, 3, 1'b1, 1'b1, 1'b1, 3, 1'b1, -1);
    xfer(1, 0, 1, 1'b0, 1'b1, 1'b0, 1, 1'b1, -1);
    // R9: divider changed mid-transfer, used only by the next transfer
    xfer(2, 3, 1, 1'b1, 1'b0, 1'b1, 3, 1'b1, 1);
    xfer(2, 1, 0, 1'b1, 1'b0, 1'b1, 2, 1'b0, -1);

    // R10: clearing the enable mid-transfer
    begin
      int e;
      logic p;
      wr(1'b1, 32'h0000_0100);
      wr(1'b0, clk_word(1'b1, 2));
      @(negedge clk);
      cs_idx = 2'd1; run = 1'b1;
      e = 0; p = 1'b1;
      for (int k = 0; k < 200 && e < 3; k++) begin
        @(negedge clk);
        if (sclk !== p) begin e++; p = sclk; end
      end
      cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = clk_word(1'b0, 2);
      @(negedge clk);
      cfg_we = 1'b0;
      @(negedge clk);
      chk("R10 cs released", int'(cs_line[1]), 1);
      chk("R10 sclk rest", int'(sclk), 1);
      run = 1'b0;
    end

    // constrained random transfers
    for (int n = 0; n < 16; n++) begin
      xfer(int'($urandom_range(3, 0)), int'($urandom_range(4, 0)),
           int'($urandom_range(3, 0)), 1'($urandom), 1'($urandom),
           1'($urandom), int'($urandom_range(4, 1)), 1'b1, -1);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule